// File: doc/BRIEF.md
# Power-Down Sequencer with Configuration Strap Latch

This block belongs to the control core of a clock generator. It has two jobs. The first runs at power-on. While reset is held, the shared configuration pins are inputs. The block samples their levels once into an internal latch and then turns the pins into outputs, so that they can carry clocks. The latched straps give the frequency select code, the core-voltage select flag and the operating mode. In mobile mode a group of function pins stays as inputs and carries the stop and power-down requests. In desktop mode those same pins become extra clock outputs.

The second job is to service the power-down request. This request is asynchronous and active low. The block first synchronizes it. It then forces every clock output group low and keeps them parked low for a set number of cycles, so that the slow reference output also has time to reach its low level. Only after that does it disable the crystal oscillator and the VCO. When the request is released, the block enables the oscillator and the VCO again and counts a programmable settle window, which stands in for the 3 ms wake limit. Only then does it release the outputs. While the block is powering down, the per-group stop requests have no effect.

Top module: `pd_strap_seq`

## Requirements
- R1: On the first clock after the internal reset is released, the strap pins are sampled once into the latch. The field positions are: `freq_sel` = pad bits [FSEL_W-1:0], mode = pad bit FSEL_W, core-voltage select `cpu_lowv` = pad bit FSEL_W+1.
- R2: `strap_pad_oe` is 0 while reset is asserted and rises to 1 together with the capture. After that, changes on the pads do not alter any latched value.
- R3: Mode bit 0 selects mobile mode (`mobile_mode`=1, `func_pin_oe`=0). Mode bit 1 selects desktop mode (`mobile_mode`=0, `func_pin_oe`=1 once the straps are captured).
- R4: In mobile mode `pd_req_n` passes through a two-stage synchronizer. When it is driven low just after a rising edge, `out_hold` is still 0 three cycles later and is 1 four cycles later. It is set on a falling clock edge.
- R5: `osc_en` and `vco_en` fall only after `out_hold` has been high for GATE_CYC cycles. With the default of 4, they are 1 six cycles after the request and 0 seven cycles after it.
- R6: While the block is sequencing power-down, `grp_run` is all zero whatever the state of `stop_req_n`.
- R7: When `pd_req_n` is released, `osc_en` and `vco_en` are 1 three cycles later. `out_hold` stays 1 for a further SETTLE_CYC cycles and is 0 at SETTLE_CYC+4 cycles after the release.
- R8: In desktop mode `pd_req_n` is ignored: `out_hold` stays 0 and `osc_en` and `vco_en` stay 1.
- R9: In mobile mode, once running, `grp_run[i]` follows `stop_req_n[i]` after two clocks of synchronization. In desktop mode `grp_run` is all ones.
- R10: While reset is asserted: `out_hold`=1, `osc_en`=`vco_en`=1, `strap_pad_oe`=0 and `func_pin_oe`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal reference clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| strap_pad_i | input | FSEL_W+2 | Levels seen on the shared strap pins |
| strap_pad_oe | output | 1 | Turns the shared strap pins to outputs after capture |
| freq_sel | output | FSEL_W | Latched frequency select code |
| mobile_mode | output | 1 | 1 when the latched mode selects mobile |
| cpu_lowv | output | 1 | Latched core-voltage select |
| func_pin_oe | output | 1 | Turns the function pins to outputs in desktop mode |
| pd_req_n | input | 1 | Asynchronous active-low power-down request |
| stop_req_n | input | NSTOP | Asynchronous active-low per-group stop requests |
| grp_run | output | NSTOP | Per-group clock run enables |
| out_hold | output | 1 | Forces every clock output low |
| osc_en | output | 1 | Crystal oscillator enable |
| vco_en | output | 1 | VCO enable |

## Verification
The bench checks the strap latch on patterns that cover both modes and both voltage levels. After each capture it inverts the pads. A latch that stays transparent would follow the inverted pads, and a direction flip at the wrong moment would show up in the output-enable checks. The power-down sequence is checked on the exact cycles around each edge. A design that skipped a synchronizer stage would raise the hold early. A design that removed the gating dwell would drop the oscillator together with the hold or before it. A short settle count would release the outputs early on wake. The bench also toggles the stop inputs in the middle of power-down, and it asserts the power-down request in desktop mode, to catch a design that lets either of these through.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

  typedef enum logic [1:0] {
    ST_RUN         = 2'd0,
    ST_GATE_LOW    = 2'd1,
    ST_OSC_OFF     = 2'd2,
    ST_WAKE_SETTLE = 2'd3
  } seq_state_e;

  // total strap field width: frequency code plus mode bit plus voltage bit
  function automatic int strap_width(input int fsel_w);
    return fsel_w + 2;
  endfunction

endpackage

// File: rtl/pwrseq_sync.sv
module pwrseq_sync #(
  parameter int   W       = 1,
  parameter logic RST_VAL = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg1_q;
  logic [W-1:0] stg2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg1_q <= {W{RST_VAL}};
      stg2_q <= {W{RST_VAL}};
    end else begin
      stg1_q <= d;
      stg2_q <= stg1_q;
    end
  end

  assign q = stg2_q;

endmodule

// File: rtl/pwrseq_strap.sv
module pwrseq_strap #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pad_i,
  output logic [W-1:0] strap_q,
  output logic         captured
);

  logic         cap_en;
  logic [W-1:0] strap_d;

  assign cap_en  = !captured;
  assign strap_d = pad_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strap_q  <= '0;
      captured <= 1'b0;
    end else if (cap_en) begin
      strap_q  <= strap_d;
      captured <= 1'b1;
    end
  end

  // R2: once captured, the latch never reopens
  p_latch_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
    captured |=> ($stable(strap_q) && captured));

endmodule

// File: rtl/pwrseq_timer.sv
module pwrseq_timer #(
  parameter int LIMIT = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic done
);

  localparam int CW = $clog2(LIMIT + 2);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt_q;
  logic          cnt_en;

  assign cnt_en = !clr && (cnt_q != LIM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign done = (cnt_q == LIM);

  // R7: a finished window stays finished until cleared
  p_done_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !clr) |=> done);

endmodule

// File: rtl/pd_strap_seq.sv
module pd_strap_seq #(
  parameter int FSEL_W     = 3,
  parameter int NSTOP      = 3,
  parameter int GATE_CYC   = 4,
  parameter int SETTLE_CYC = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FSEL_W+1:0] strap_pad_i,
  output logic              strap_pad_oe,
  output logic [FSEL_W-1:0] freq_sel,
  output logic              mobile_mode,
  output logic              cpu_lowv,
  output logic              func_pin_oe,
  input  logic              pd_req_n,
  input  logic [NSTOP-1:0]  stop_req_n,
  output logic [NSTOP-1:0]  grp_run,
  output logic              out_hold,
  output logic              osc_en,
  output logic              vco_en
);
  import pwrseq_pkg::*;

  localparam int STRAP_W  = strap_width(FSEL_W);
  localparam int MODE_BIT = FSEL_W;
  localparam int LOWV_BIT = FSEL_W + 1;

  logic               rst_int_n;
  logic               pd_s_n;
  logic [NSTOP-1:0]   stop_s_n;
  logic [STRAP_W-1:0] strap_q;
  logic               captured;
  logic               pd_act;
  logic               gate_clr, gate_done;
  logic               settle_clr, settle_done;
  logic               hold_d, hold_q;
  seq_state_e         state_q, state_d;

  // reset released synchronously
  pwrseq_sync #(.W(1), .RST_VAL(1'b0)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_int_n));

  pwrseq_sync #(.W(1), .RST_VAL(1'b1)) u_pd_sync (
    .clk(clk), .rst_n(rst_int_n), .d(pd_req_n), .q(pd_s_n));

  pwrseq_sync #(.W(NSTOP), .RST_VAL(1'b1)) u_stop_sync (
    .clk(clk), .rst_n(rst_int_n), .d(stop_req_n), .q(stop_s_n));

  pwrseq_strap #(.W(STRAP_W)) u_strap (
    .clk(clk), .rst_n(rst_int_n), .pad_i(strap_pad_i),
    .strap_q(strap_q), .captured(captured));

  assign freq_sel     = strap_q[FSEL_W-1:0];
  assign mobile_mode  = !strap_q[MODE_BIT];
  assign cpu_lowv     = strap_q[LOWV_BIT];
  assign strap_pad_oe = captured;
  assign func_pin_oe  = captured && strap_q[MODE_BIT];

  assign pd_act = captured && mobile_mode && !pd_s_n;

  assign gate_clr   = (state_q != ST_GATE_LOW);
  assign settle_clr = (state_q != ST_WAKE_SETTLE);

  pwrseq_timer #(.LIMIT(GATE_CYC - 1)) u_gate_tmr (
    .clk(clk), .rst_n(rst_int_n), .clr(gate_clr), .done(gate_done));

  pwrseq_timer #(.LIMIT(SETTLE_CYC - 1)) u_settle_tmr (
    .clk(clk), .rst_n(rst_int_n), .clr(settle_clr), .done(settle_done));

  // next-state logic
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN:         if (pd_act)      state_d = ST_GATE_LOW;
      ST_GATE_LOW:    if (gate_done)   state_d = ST_OSC_OFF;
      ST_OSC_OFF:     if (!pd_act)     state_d = ST_WAKE_SETTLE;
      ST_WAKE_SETTLE: if (settle_done) state_d = ST_RUN;
      default:                         state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) state_q <= ST_RUN;
    else            state_q <= state_d;
  end

  // outputs park low on the falling edge after the state leaves RUN
  assign hold_d = (state_q != ST_RUN) || !captured;

  always_ff @(negedge clk or negedge rst_int_n) begin
    if (!rst_int_n) hold_q <= 1'b1;
    else            hold_q <= hold_d;
  end

  assign out_hold = hold_q;
  assign osc_en   = (state_q != ST_OSC_OFF);
  assign vco_en   = (state_q != ST_OSC_OFF);

  for (genvar g = 0; g < NSTOP; g++) begin : g_grp
    assign grp_run[g] = !hold_q && (!mobile_mode || stop_s_n[g]);
  end

  // R5: oscillator is off only while outputs are parked low
  p_osc_after_hold_r5: assert property (@(posedge clk) disable iff (!rst_int_n)
    !osc_en |-> out_hold);

  // R6: no group runs while power-down is in progress
  p_groups_quiet_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (state_q != ST_RUN) |-> (grp_run == '0));

  // R7: oscillator returns while outputs are still held
  p_wake_held_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(osc_en) |-> out_hold);

  // R8: desktop mode never leaves RUN
  p_desktop_runs_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
    (captured && !mobile_mode) |-> (state_q == ST_RUN));

  // R2: pin direction flips once and stays
  p_pad_oe_keeps_r2: assert property (@(posedge clk) disable iff (!rst_int_n)
    strap_pad_oe |=> strap_pad_oe);

endmodule

// File: tb/sim_pd_strap_seq.sv
module sim_pd_strap_seq;

  logic       clk;
  logic       rst_n;
  logic [4:0] strap_pad_i;
  logic       strap_pad_oe;
  logic [2:0] freq_sel;
  logic       mobile_mode;
  logic       cpu_lowv;
  logic       func_pin_oe;
  logic       pd_req_n;
  logic [2:0] stop_req_n;
  logic [2:0] grp_run;
  logic       out_hold;
  logic       osc_en;
  logic       vco_en;

  int n_vec;
  int n_bad;

  pd_strap_seq #(.FSEL_W(3), .NSTOP(3), .GATE_CYC(4), .SETTLE_CYC(16)) u0 (
    .clk(clk), .rst_n(rst_n), .strap_pad_i(strap_pad_i),
    .strap_pad_oe(strap_pad_oe), .freq_sel(freq_sel),
    .mobile_mode(mobile_mode), .cpu_lowv(cpu_lowv),
    .func_pin_oe(func_pin_oe), .pd_req_n(pd_req_n),
    .stop_req_n(stop_req_n), .grp_run(grp_run), .out_hold(out_hold),
    .osc_en(osc_en), .vco_en(vco_en));

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // {pad[4:0], exp freq[2:0], exp mobile, exp lowv, exp func_pin_oe}
  localparam logic [10:0] VEC [6] = '{
    11'b00101_101_1_0_0,
    11'b11010_010_0_1_1,
    11'b01111_111_0_0_1,
    11'b10000_000_1_1_0,
    11'b11110_110_0_1_1,
    11'b00011_011_1_0_0
  };

  task automatic tick(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      #5;
    end
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [4:0] pads);
    rst_n       = 1'b0;
    strap_pad_i = pads;
    tick(3);
    rst_n = 1'b1;
    tick(6);
  endtask

  initial begin
    #4000000;
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    n_vec      = 0;
    n_bad      = 0;
    rst_n      = 1'b0;
    pd_req_n   = 1'b1;
    stop_req_n = 3'b111;
    strap_pad_i = 5'b00000;
    tick(3);

    // R10: reset state
    chk("R10 hold", 32'(out_hold), 32'd1);
    chk("R10 osc", 32'(osc_en), 32'd1);
    chk("R10 vco", 32'(vco_en), 32'd1);
    chk("R10 pad_oe", 32'(strap_pad_oe), 32'd0);
    chk("R10 func_oe", 32'(func_pin_oe), 32'd0);

    // strap vectors: R1, R2, R3
    for (int i = 0; i < 6; i++) begin
      logic [4:0] pads;
      pads = VEC[i][10:6];
      rst_n = 1'b0;
      strap_pad_i = pads;
      tick(3);
      chk("R2 oe in reset", 32'(strap_pad_oe), 32'd0);
      rst_n = 1'b1;
      tick(6);
      chk("R2 oe after capture", 32'(strap_pad_oe), 32'd1);
      chk("R1 freq", 32'(freq_sel), 32'(VEC[i][5:3]));
      chk("R3 mobile", 32'(mobile_mode), 32'(VEC[i][2]));
      chk("R1 lowv", 32'(cpu_lowv), 32'(VEC[i][1]));
      chk("R3 func_oe", 32'(func_pin_oe), 32'(VEC[i][0]));
      strap_pad_i = ~pads;
      tick(4);
      chk("R2 freq frozen", 32'(freq_sel), 32'(VEC[i][5:3]));
      chk("R2 mobile frozen", 32'(mobile_mode), 32'(VEC[i][2]));
      chk("R2 lowv frozen", 32'(cpu_lowv), 32'(VEC[i][1]));
    end

    // mobile power-down sequence
    do_reset(5'b00101);
    chk("R9 mobile all run", 32'(grp_run), 32'h7);
    pd_req_n = 1'b0;
    tick(3);
    chk("R4 hold not early", 32'(out_hold), 32'd0);
    tick(1);
    chk("R4 hold set", 32'(out_hold), 32'd1);
    chk("R6 groups low", 32'(grp_run), 32'd0);
    tick(2);
    chk("R5 osc still on", 32'(osc_en), 32'd1);
    tick(1);
    chk("R5 osc off", 32'(osc_en), 32'd0);
    chk("R5 vco off", 32'(vco_en), 32'd0);
    stop_req_n = 3'b000;
    tick(2);
    stop_req_n = 3'b111;
    tick(3);
    chk("R6 stops ignored", 32'(grp_run), 32'd0);
    chk("R6 still off", 32'(osc_en), 32'd0);

    // wake
    pd_req_n = 1'b1;
    tick(3);
    chk("R7 osc back", 32'(osc_en), 32'd1);
    chk("R7 vco back", 32'(vco_en), 32'd1);
    chk("R7 hold during settle", 32'(out_hold), 32'd1);
    tick(16);
    chk("R7 hold until settle end", 32'(out_hold), 32'd1);
    tick(1);
    chk("R7 hold released", 32'(out_hold), 32'd0);
    chk("R9 groups resume", 32'(grp_run), 32'h7);
    stop_req_n = 3'b101;
    tick(3);
    chk("R9 group stop", 32'(grp_run), 32'h5);
    stop_req_n = 3'b111;
    tick(3);
    chk("R9 group restart", 32'(grp_run), 32'h7);

    // desktop: power-down and stops ignored
    do_reset(5'b11010);
    pd_req_n   = 1'b0;
    stop_req_n = 3'b000;
    tick(30);
    chk("R8 hold stays low", 32'(out_hold), 32'd0);
    chk("R8 osc stays on", 32'(osc_en), 32'd1);
    chk("R8 vco stays on", 32'(vco_en), 32'd1);
    chk("R9 desktop groups run", 32'(grp_run), 32'h7);
    chk("R3 desktop func_oe", 32'(func_pin_oe), 32'd1);
    pd_req_n   = 1'b1;
    stop_req_n = 3'b111;
    tick(2);

    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule